// File: doc/BRIEF.md
# Mode-Selectable Comb Decimation Front End

This block is the first decimation section after a sigma-delta modulator in a receiver that serves three radio standards. Samples arrive with a valid strobe. They pass through a chain of up to three multiplier-free comb stages. Each stage filters with a non-recursive (1+z^-1)^K kernel and then keeps every second result, so each stage halves the sample rate.

A 2-bit mode input picks the standard. The mode sets how many comb stages run: one, two or three, for oversampling ratios of 8, 16 and 32. The remaining two halves of the decimation are done by halfband stages further down the chain. The mode also sets which stage output drives the shared output. Stages the mode does not use get no clock enable and hold still.

Each mode has its own input word width. Data is sign-extended from that width, and the wider bits of the input port are ignored. When the mode changes, all filter state is flushed. The output stays silent until the newly selected path has filled again.

Top module: `comb_decim_front`

## Requirements
- R1: While reset is asserted and right after it is released, out_valid is 0 and out_data is 0.
- R2: Mode 2'b00 runs one stage, 2'b01 runs two stages and 2'b10 runs three stages. The output is always taken from the last active stage.
- R3: Each stage computes y[n] = sum over k=0..K of C(K,k)·x[n−k], with K = 6 by default. Samples are counted n = 0, 1, 2… from the last flush. A stage emits y[n] only for odd n with n ≥ K. Its DC gain is therefore 2^K.
- R4: The input is sign-extended from bit 5 in mode 2'b00, from bit 6 in mode 2'b01, and from bit 7 in mode 2'b10. Input bits above that sign bit have no effect on the output.
- R5: In mode 2'b11 no stage runs and out_valid stays 0.
- R6: A mode change flushes every stage in the cycle it is first seen. A sample presented in that cycle is dropped. After a flush, the first output follows the 8th accepted input in mode 2'b00.
- R7: With continuous input, valid outputs in steady state are single-cycle pulses spaced exactly 2^N cycles apart, where N is the number of active stages.
- R8: Each stage adds one register. Counting the edge that accepts input k as edge k, with continuous input after a flush, the first output appears after edge 7 in mode 2'b00, after edge 22 in mode 2'b01 and after edge 51 in mode 2'b10.
- R9: out_data is the full-precision stage result, sign-extended to IN_W+3K bits. A full-scale input of −128 held in mode 2'b10 yields −33554432 without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Standard select: 00 ratio 8, 01 ratio 16, 10 ratio 32, 11 off |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IN_W (8) | Modulator sample in two's complement; width used depends on mode |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | IN_W+3K (26) | Decimated sample, sign-extended |

## Verification
A behavioural reference model runs every mode on random data with random valid gaps. Any error in the kernel coefficients, the decimation phase or the refill count shows up as a value or timing mismatch. Constant inputs of small, negative and full-scale value separate gain and sign-extension faults from coefficient faults. Inputs whose bits above the mode's sign bit are garbage expose a wrong width choice.

Continuous streams measure the first-output latency and the spacing of outputs per mode, which isolates stage count and tap selection. A mode switch with a sample pending in the switch cycle, and a run in the off mode, show whether flushing and gating behave as required.

// File: rtl/comb_decim_pkg.sv
package comb_decim_pkg;

   typedef enum logic [1:0] {
      MODE_X8  = 2'b00,
      MODE_X16 = 2'b01,
      MODE_X32 = 2'b10,
      MODE_OFF = 2'b11
   } mode_e;

   localparam int unsigned NUM_STAGES = 3;

   // number of comb stages a mode runs
   function automatic int unsigned active_stages(mode_e m);
      case (m)
         MODE_X8:  return 1;
         MODE_X16: return 2;
         MODE_X32: return 3;
         default:  return 0;
      endcase
   endfunction

endpackage

// File: rtl/comb_dec2.sv
module comb_dec2 #(
   parameter int unsigned IW = 8,
   parameter int unsigned K  = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic                 clr,
   input  logic                 in_v,
   input  logic signed [IW-1:0] in_d,
   output logic                 out_v,
   output logic signed [IW+K-1:0] out_d
);
   localparam int unsigned OW = IW + K;
   localparam int unsigned CW = $clog2(K + 1);

   if (K < 1 || K > 12) begin : g_bad_k
      $error("comb_dec2: K out of range");
   end
   if (IW < 2) begin : g_bad_iw
      $error("comb_dec2: IW too small");
   end

   logic signed [OW-1:0] sec  [K+1];
   logic signed [OW-1:0] prev [K];
   logic [CW-1:0]        cnt;
   logic                 ph;
   logic                 filled;
   logic                 accept;

   assign sec[0] = OW'(in_d);

   // K cascaded (1 + z^-1) sections, each with its own delay register
   for (genvar j = 0; j < K; j++) begin : g_sec
      assign sec[j+1] = sec[j] + prev[j];
   end

   assign filled = (cnt == CW'(K));
   assign accept = en & ~clr & in_v;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         for (int j = 0; j < K; j++) prev[j] <= '0;
         cnt   <= '0;
         ph    <= 1'b0;
         out_v <= 1'b0;
         out_d <= '0;
      end else if (en) begin
         out_v <= accept & ph & filled;
         if (accept) begin
            for (int j = 0; j < K; j++) prev[j] <= sec[j];
            ph <= ~ph;
            if (!filled) cnt <= cnt + 1'b1;
            if (ph && filled) out_d <= sec[K];
         end
      end
   end

   // R7: an emitted sample needs two accepted inputs, so a pulse never repeats
   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      out_v |=> !out_v);

   // R6: no output before the delay line has been refilled
   a_r6_refill_before_out: assert property (@(posedge clk) disable iff (!rst_n)
      out_v |-> filled);

endmodule

// File: rtl/comb_mode_ctrl.sv
module comb_mode_ctrl
   import comb_decim_pkg::*;
#(
   parameter int unsigned IN_W  = 8,
   parameter int unsigned W_X8  = 6,
   parameter int unsigned W_X16 = 7,
   parameter int unsigned W_X32 = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             mode_in,
   input  logic                   in_valid,
   input  logic [IN_W-1:0]        in_data,
   output logic                   flush,
   output mode_e                  mode_q,
   output logic [NUM_STAGES-1:0]  stage_en,
   output logic                   head_valid,
   output logic signed [IN_W-1:0] head_data
);
   if (W_X8 < 2 || W_X8 > IN_W || W_X16 < 2 || W_X16 > IN_W ||
       W_X32 < 2 || W_X32 > IN_W) begin : g_bad_w
      $error("comb_mode_ctrl: mode width exceeds IN_W");
   end

   function automatic logic [IN_W-1:0] sext(logic [IN_W-1:0] d, int unsigned w);
      logic [IN_W-1:0] r;
      for (int b = 0; b < IN_W; b++) r[b] = (b < w) ? d[b] : d[w-1];
      return r;
   endfunction

   assign flush = (mode_in != mode_q);

   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= MODE_OFF;
      else if (flush) mode_q <= mode_e'(mode_in);
   end

   always_comb begin
      for (int i = 0; i < NUM_STAGES; i++)
         stage_en[i] = (i < active_stages(mode_q));
   end

   always_comb begin
      case (mode_q)
         MODE_X8:  head_data = $signed(sext(in_data, W_X8));
         MODE_X16: head_data = $signed(sext(in_data, W_X16));
         default:  head_data = $signed(sext(in_data, W_X32));
      endcase
   end

   assign head_valid = in_valid & ~flush;

   // R6: the mode register follows a changed mode input one edge later
   a_r6_mode_follows: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !$stable(mode_q));

endmodule

// File: rtl/comb_decim_front.sv
module comb_decim_front
   import comb_decim_pkg::*;
#(
   parameter int unsigned IN_W  = 8,
   parameter int unsigned K     = 6,
   parameter int unsigned W_X8  = 6,
   parameter int unsigned W_X16 = 7,
   parameter int unsigned W_X32 = 8,
   localparam int unsigned OUT_W = IN_W + NUM_STAGES * K
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode,
   input  logic             in_valid,
   input  logic [IN_W-1:0]  in_data,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_data
);
   logic                   flush;
   mode_e                  mode_q;
   logic [NUM_STAGES-1:0]  stage_en;
   logic                   head_valid;
   logic signed [IN_W-1:0] head_data;
   logic [NUM_STAGES-1:0]  tap_v;
   logic signed [OUT_W-1:0] tap_d [NUM_STAGES];

   comb_mode_ctrl #(
      .IN_W (IN_W),
      .W_X8 (W_X8),
      .W_X16(W_X16),
      .W_X32(W_X32)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_in   (mode),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .flush     (flush),
      .mode_q    (mode_q),
      .stage_en  (stage_en),
      .head_valid(head_valid),
      .head_data (head_data)
   );

   for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
      localparam int unsigned SIW = IN_W + i * K;
      logic                    st_in_v;
      logic signed [SIW-1:0]   st_in_d;
      logic                    st_out_v;
      logic signed [SIW+K-1:0] st_out;

      if (i == 0) begin : g_head
         assign st_in_v = head_valid;
         assign st_in_d = head_data;
      end else begin : g_link
         assign st_in_v = g_stage[i-1].st_out_v;
         assign st_in_d = g_stage[i-1].st_out;
      end

      comb_dec2 #(.IW(SIW), .K(K)) u_comb (
         .clk  (clk),
         .rst_n(rst_n),
         .en   (stage_en[i]),
         .clr  (flush),
         .in_v (st_in_v),
         .in_d (st_in_d),
         .out_v(st_out_v),
         .out_d(st_out)
      );

      assign tap_v[i] = st_out_v;
      assign tap_d[i] = OUT_W'(st_out);
   end

   // output multiplexer: tap the last stage the mode runs
   always_comb begin
      out_valid = 1'b0;
      out_data  = '0;
      for (int i = 0; i < NUM_STAGES; i++) begin
         if (active_stages(mode_q) == i + 1) begin
            out_valid = tap_v[i];
            out_data  = tap_d[i];
         end
      end
   end

   // R5: the off mode never produces a sample
   a_r5_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_OFF) |-> !out_valid);

   // R6: the edge after a flush leaves every stage output empty
   a_r6_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !out_valid);

endmodule

// File: tb/comb_decim_front_test.sv
`timescale 1ns/1ps
module comb_decim_front_test;
   localparam int IN_W  = 8;
   localparam int K     = 6;
   localparam int OUT_W = IN_W + 3 * K;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] mode = 2'b11;
   logic in_valid = 1'b0;
   logic [IN_W-1:0] in_data = '0;
   logic out_valid;
   logic [OUT_W-1:0] out_data;

   always #2.5 clk = ~clk;

   comb_decim_front uut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid),
      .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   // behavioural reference state
   longint bin [0:K];
   longint hist [3][0:K];
   int     cnt [3];
   bit     ph [3];
   bit     ov [3];
   longint od [3];
   int     mq = 3;
   bit     exp_v;
   longint exp_d;

   task automatic fail_chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   function automatic longint sx(int d, int w);
      longint v = d & ((1 << w) - 1);
      if (v >= (longint'(1) << (w - 1))) v -= (longint'(1) << w);
      return v;
   endfunction

   function automatic int mode_w(int m);
      return (m == 0) ? 6 : (m == 1) ? 7 : 8;
   endfunction

   task automatic model_clear();
      for (int i = 0; i < 3; i++) begin
         for (int k = 0; k <= K; k++) hist[i][k] = 0;
         cnt[i] = 0; ph[i] = 0; ov[i] = 0; od[i] = 0;
      end
   endtask

   task automatic model_edge(bit v, int d, int m);
      bit     ov_o [3];
      longint od_o [3];
      if (m != mq) begin
         model_clear();
         mq = m;
      end else if (mq < 3) begin
         for (int i = 0; i < 3; i++) begin ov_o[i] = ov[i]; od_o[i] = od[i]; end
         for (int i = 0; i <= mq; i++) begin
            bit iv = (i == 0) ? v : ov_o[i-1];
            longint x = (i == 0) ? sx(d, mode_w(mq)) : od_o[i-1];
            if (iv) begin
               longint y = 0;
               for (int k = K; k > 0; k--) hist[i][k] = hist[i][k-1];
               hist[i][0] = x;
               for (int k = 0; k <= K; k++) y += bin[k] * hist[i][k];
               ov[i] = ph[i] && (cnt[i] >= K);
               if (ov[i]) od[i] = y;
               ph[i] = !ph[i];
               if (cnt[i] < K) cnt[i]++;
            end else begin
               ov[i] = 0;
            end
         end
      end
      exp_v = (mq < 3) ? ov[mq] : 0;
      exp_d = (mq < 3) ? od[mq] : 0;
   endtask

   // one clock: drive at negedge, model at the edge, compare at next negedge
   task automatic step(bit v, int d, int m, string tag);
      in_valid = v; in_data = IN_W'(d); mode = m[1:0];
      @(posedge clk);
      model_edge(v, d, m);
      @(negedge clk);
      fail_chk(out_valid === exp_v, tag, "out_valid", longint'(out_valid), longint'(exp_v));
      if (exp_v)
         fail_chk($signed(out_data) == exp_d, tag, "out_data",
                  longint'($signed(out_data)), exp_d);
   endtask

   task automatic settle(int m);
      for (int i = 0; i < 3; i++) step(0, 0, m, "R6");
   endtask

   // continuous stream; reports index of first output and last two output cycles
   task automatic run_const(int m, int d, int n, string tag,
                            output int first_k, output longint last_d,
                            output int gap);
      int prev_c = -1;
      first_k = -1; last_d = 0; gap = 0;
      for (int k = 0; k < n; k++) begin
         step(1, d, m, tag);
         if (out_valid) begin
            if (first_k < 0) first_k = k;
            if (prev_c >= 0) gap = k - prev_c;
            prev_c = k;
            last_d = $signed(out_data);
         end
      end
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin : main
      int fk;
      longint ld;
      int gp;
      int nv;

      bin[0] = 1;
      for (int k = 1; k <= K; k++) bin[k] = bin[k-1] * (K - k + 1) / k;
      model_clear();

      repeat (4) @(negedge clk);
      // R1: reset state
      fail_chk(out_valid === 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
      fail_chk(out_data === '0, "R1", "out_data in reset", longint'(out_data), 0);
      rst_n = 1'b1;
      @(negedge clk);
      fail_chk(out_valid === 1'b0, "R1", "out_valid after reset", longint'(out_valid), 0);
      fail_chk(out_data === '0, "R1", "out_data after reset", longint'(out_data), 0);

      // R8 / R2 / R3: latency and DC gain per mode
      settle(0);
      run_const(0, 3, 40, "R8", fk, ld, gp);
      fail_chk(fk == 7, "R8", "first output edge x8", fk, 7);
      fail_chk(ld == 3 * 64, "R3", "DC gain x8", ld, 192);
      fail_chk(gp == 2, "R7", "output spacing x8", gp, 2);

      settle(1);
      run_const(1, -3, 120, "R8", fk, ld, gp);
      fail_chk(fk == 22, "R8", "first output edge x16", fk, 22);
      fail_chk(ld == -3 * 4096, "R2", "DC gain x16", ld, -12288);
      fail_chk(gp == 4, "R7", "output spacing x16", gp, 4);

      settle(2);
      run_const(2, -128, 200, "R9", fk, ld, gp);
      fail_chk(fk == 51, "R8", "first output edge x32", fk, 51);
      fail_chk(ld == -33554432, "R9", "full-scale x32", ld, -33554432);
      fail_chk(gp == 8, "R7", "output spacing x32", gp, 8);

      // R4: upper bits are ignored in the 6-bit mode (low bits = 5)
      settle(0);
      ld = 0;
      for (int k = 0; k < 60; k++) begin
         step(1, ($urandom_range(0, 3) << 6) | 5, 0, "R4");
         if (out_valid) ld = $signed(out_data);
      end
      fail_chk(ld == 5 * 64, "R4", "garbage upper bits x8", ld, 320);

      // R4: bit 7 ignored in the 7-bit mode (low bits = 7'h7f = -1)
      settle(1);
      ld = 0;
      for (int k = 0; k < 120; k++) begin
         step(1, ($urandom_range(0, 1) << 7) | 8'h7f, 1, "R4");
         if (out_valid) ld = $signed(out_data);
      end
      fail_chk(ld == -4096, "R4", "garbage bit 7 x16", ld, -4096);

      // R3: random data with random gaps in every active mode
      for (int m = 0; m < 3; m++) begin
         settle(m);
         for (int k = 0; k < 1500; k++)
            step($urandom_range(0, 3) != 0, $urandom_range(0, 255), m, "R3");
      end

      // R5: off mode stays silent
      nv = 0;
      for (int k = 0; k < 80; k++) begin
         step(1, $urandom_range(0, 255), 3, "R5");
         if (out_valid) nv++;
      end
      fail_chk(nv == 0, "R5", "valid pulses in off mode", nv, 0);

      // R6: switch 16x -> 8x with a sample pending in the switch cycle
      settle(1);
      for (int k = 0; k < 50; k++) step(1, $urandom_range(0, 255), 1, "R6");
      step(1, 8'h3f, 0, "R6");   // dropped
      fail_chk(out_valid === 1'b0, "R6", "valid right after flush", longint'(out_valid), 0);
      fk = -1;
      for (int k = 0; k < 20; k++) begin
         step(1, 2, 0, "R6");
         if (out_valid && fk < 0) fk = k;
      end
      fail_chk(fk == 7, "R6", "inputs before first output after switch", fk, 7);

      // R6: switch 32x -> 16x mid stream, random afterwards
      settle(2);
      for (int k = 0; k < 100; k++) step(1, $urandom_range(0, 255), 2, "R6");
      for (int k = 0; k < 300; k++) step($urandom_range(0, 1), $urandom_range(0, 255), 1, "R6");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule